// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the device side of a two-wire serial memory. It watches a clock line and an open-drain data line, and answers a bus master that wants to read or write a byte-wide memory array. Both lines are sampled with the system clock. The block finds START and STOP conditions on these samples, checks a device select byte against a fixed code and three strap pins, and then takes a two-byte word address followed by data bytes, or returns data bytes. Data on the line is driven only by pulling it low, through an output enable.

Writes first collect in a 32-byte page buffer and reach the array only when a STOP closes the write. The slave then stays off the bus for a programmable number of system-clock ticks, which stands in for the internal programming time. A protect input fences off the upper quarter of the array. The array holds 2^ADDR_W bytes. The default of 11 keeps elaboration light, and 13 gives the full 8 KiB part.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START (data falls while the clock is high) begins a transfer. A STOP (data rises while the clock is high) ends it and releases SDA. A byte clocked in without a preceding START is not acknowledged.
- R2: The first byte after a START is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `dev_sel`. Bit 0 is the direction, with 1 for read and 0 for write. Any other device select byte gets no acknowledge.
- R3: In a write, the slave pulls SDA low during the ninth clock after the device select byte, after each word-address byte and after each data byte.
- R4: A write carries two word-address bytes, high byte first, and only the low ADDR_W bits of the 16 are used.
- R5: A read sends 8 bits MSB first, then releases SDA. If the master drives an acknowledge low, the slave sends the next byte.
- R6: After a master no-acknowledge the slave keeps SDA released until the next START or STOP.
- R7: Buffered write data reaches the array only at a STOP. A repeated START before the STOP discards it.
- R8: For WR_TICKS clocks after a STOP that commits data, the slave acknowledges no device select byte and keeps SDA released. After that window it answers again.
- R9: During a write, the low 5 address bits advance after each data byte and wrap inside the current 32-byte page.
- R10: The read address advances after each byte sent and wraps from the top address to 0.
- R11: A read started without a new word address begins at the address that follows the last byte transferred.
- R12: While `wp_i` is 1, bytes whose two top address bits are 11 (the upper quarter) are not written. While it is 0, the whole array is writable.
- R13: `sda_oe` changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| dev_sel | input | 3 | Strap pins compared with device select bits 3..1 |
| wp_i | input | 1 | Write protect for the upper quarter of the array |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |

## Verification
Each line passes through two synchronizer flops and one edge register, so every change of `sda_oe` appears three system clocks after the SCL fall that causes it. A write reaches the array three clocks after the SDA rise of the STOP. The bench holds each quarter of an SCL period for eight clocks and reads SDA halfway through the high phase, which is well after any of these latencies. After a committing STOP it waits WR_TICKS plus 100 clocks before it expects the device to answer again. The busy-window check instead probes the device within about 300 clocks of the STOP, which is well inside the window.

// File: rtl/eei_pkg.sv
`timescale 1ns/1ps
package eei_pkg;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int         PAGE_W   = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DACK, S_AHI, S_HACK, S_ALO, S_LACK,
    S_WDAT, S_WACK, S_RDAT, S_RACK
  } state_t;

  // device select byte matches the fixed code and the strap pins
  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] pins);
    return (b[7:4] == DEV_CODE) && (b[3:1] == pins);
  endfunction

  // next write address: low PAGE_W bits roll over inside the page
  function automatic logic [15:0] page_step(input logic [15:0] a);
    return {a[15:PAGE_W], a[PAGE_W-1:0] + 5'd1};
  endfunction

  // upper quarter of a 2^aw array is locked while wp is set
  function automatic logic in_locked_zone(input logic [15:0] a, input int aw, input logic wp);
    return wp && a[aw-1] && a[aw-2];
  endfunction

endpackage

// File: rtl/eei_bus_front.sv
`timescale 1ns/1ps
module eei_bus_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eei_engine.sv
`timescale 1ns/1ps
module eei_engine
  import eei_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [2:0]        pins,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] ptr,
  output logic              buf_we,
  output logic [4:0]        buf_idx,
  output logic [7:0]        buf_din
);
  state_t     st;
  logic [2:0] cnt;
  logic       got, rw, mack;
  logic [7:0] sh, tx, hi;

  wire receiving = st inside {S_DEV, S_AHI, S_ALO, S_WDAT};
  wire byte_end  = scl_fall && got;
  wire addr_hit  = dev_hit(sh, pins) && !busy;
  wire [ADDR_W-1:0] ptr_page = ADDR_W'(page_step(16'(ptr)));
  wire [ADDR_W-1:0] ptr_seq  = ptr + ADDR_W'(1);

  assign buf_we  = byte_end && (st == S_WDAT);
  assign buf_idx = ptr[4:0];
  assign buf_din = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; got <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      sh <= '0; tx <= '0; hi <= '0; sda_oe <= 1'b0; ptr <= '0;
    end else if (start_ev) begin
      st <= S_DEV; cnt <= '0; got <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st <= S_IDLE; got <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (scl_rise) begin
        if (receiving) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) got <= 1'b1;
        end else if (st == S_RDAT) begin
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) got <= 1'b1;
        end else if (st == S_RACK) begin
          mack <= !sda_s;
        end
      end
      if (scl_fall) begin
        case (st)
          S_DEV: if (got) begin
            got <= 1'b0;
            if (addr_hit) begin rw <= sh[0]; sda_oe <= 1'b1; st <= S_DACK; end
            else st <= S_IDLE;
          end
          S_AHI: if (got) begin got <= 1'b0; hi <= sh; sda_oe <= 1'b1; st <= S_HACK; end
          S_ALO: if (got) begin
            got <= 1'b0; ptr <= ADDR_W'({hi, sh}); sda_oe <= 1'b1; st <= S_LACK;
          end
          S_WDAT: if (got) begin got <= 1'b0; ptr <= ptr_page; sda_oe <= 1'b1; st <= S_WACK; end
          S_DACK: begin
            if (rw) begin tx <= rd_data; sda_oe <= ~rd_data[7]; st <= S_RDAT; end
            else begin sda_oe <= 1'b0; st <= S_AHI; end
          end
          S_HACK: begin sda_oe <= 1'b0; st <= S_ALO; end
          S_LACK, S_WACK: begin sda_oe <= 1'b0; st <= S_WDAT; end
          S_RDAT: begin
            if (got) begin got <= 1'b0; sda_oe <= 1'b0; ptr <= ptr_seq; st <= S_RACK; end
            else begin tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; end
          end
          S_RACK: begin
            if (mack) begin tx <= rd_data; sda_oe <= ~rd_data[7]; st <= S_RDAT; end
            else st <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  p_start_dev_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == S_DEV));
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == S_IDLE && !sda_oe));
  p_dev_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DACK) |-> sda_oe);
  p_write_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HACK || st == S_LACK || st == S_WACK) |-> sda_oe);
  p_master_ack_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK) |-> !sda_oe);
endmodule

// File: rtl/eei_store.sv
`timescale 1ns/1ps
module eei_store
  import eei_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int WR_TICKS = 2_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_we,
  input  logic [4:0]               buf_idx,
  input  logic [7:0]               buf_din,
  input  logic                     buf_clr,
  input  logic                     commit_req,
  input  logic [ADDR_W-PAGE_W-1:0] page,
  input  logic                     wp,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  output logic                     busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;
  localparam int TW    = $clog2(WR_TICKS + 1);

  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [SLOTS];
  logic [SLOTS-1:0] vld, slot_ok;
  logic [TW-1:0]    tmr;

  wire commit = commit_req && (|vld);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_ok[g] = vld[g] && !in_locked_zone(16'({page, PAGE_W'(g)}), ADDR_W, wp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      tmr <= '0;
    end else if (commit) begin
      vld <= '0;
      tmr <= TW'(WR_TICKS);
    end else begin
      if (buf_clr) vld <= '0;
      else if (buf_we) vld[buf_idx] <= 1'b1;
      if (tmr != '0) tmr <= tmr - TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_din;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (slot_ok[i]) mem[{page, PAGE_W'(i)}] <= pbuf[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];
  assign busy    = (tmr != '0);

  p_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);
  p_busy_no_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_we);
endmodule

// File: rtl/i2c_eeprom_slave.sv
`timescale 1ns/1ps
module i2c_eeprom_slave #(
  parameter int ADDR_W   = 11,
  parameter int WR_TICKS = 2_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel,
  input  logic       wp_i,
  output logic       sda_oe
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, buf_we;
  logic [4:0] buf_idx;
  logic [7:0] buf_din, rd_data;
  logic [ADDR_W-1:0] ptr;

  eei_bus_front #(.STAGES(2)) u_front (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  eei_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev), .pins(dev_sel),
    .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_din(buf_din));

  eei_store #(.ADDR_W(ADDR_W), .WR_TICKS(WR_TICKS)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_din(buf_din), .buf_clr(start_ev), .commit_req(stop_ev),
    .page(ptr[ADDR_W-1:eei_pkg::PAGE_W]), .wp(wp_i), .rd_addr(ptr),
    .rd_data(rd_data), .busy(busy));

  p_oe_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  p_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_slave;
  localparam int TICKS = 2000;
  localparam int WT    = TICKS + 100;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'd5;
  logic dut_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  wire sda_line = m_sda & ~dut_oe;

  always #2.5 clk = ~clk;

  i2c_eeprom_slave #(.ADDR_W(11), .WR_TICKS(TICKS)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .dev_sel(pins), .wp_i(wp), .sda_oe(dut_oe));

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(input logic [2:0] p, input bit rd);
    return {4'b1010, p, rd};
  endfunction

  task automatic b_start();
    m_sda = 1'b1; cyc(Q); m_scl = 1'b1; cyc(Q); m_sda = 1'b0; cyc(Q); m_scl = 1'b0; cyc(Q);
  endtask

  task automatic b_stop();
    m_sda = 1'b0; cyc(Q); m_scl = 1'b1; cyc(Q); m_sda = 1'b1; cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; cyc(Q); m_scl = 1'b1; cyc(2*Q); m_scl = 1'b0; cyc(Q);
    end
    m_sda = 1'b1; cyc(Q); m_scl = 1'b1; cyc(Q);
    ack = (sda_line == 1'b0);
    cyc(Q); m_scl = 1'b0; cyc(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; cyc(Q); m_scl = 1'b1; cyc(Q);
      b[i] = sda_line;
      cyc(Q); m_scl = 1'b0; cyc(Q);
    end
    m_sda = !mack; cyc(Q); m_scl = 1'b1; cyc(2*Q); m_scl = 1'b0; cyc(Q);
    m_sda = 1'b1;
  endtask

  // set the read pointer with a dummy write, then restart as a read
  task automatic rd_point(input logic [15:0] a, input string req);
    bit k;
    b_start();
    send_byte(dev(pins, 0), k); chk(req, k, 1);
    send_byte(a[15:8], k);      chk(req, k, 1);
    send_byte(a[7:0], k);       chk(req, k, 1);
    b_start();
    send_byte(dev(pins, 1), k); chk(req, k, 1);
  endtask

  task automatic wr_byte(input logic [15:0] a, input logic [7:0] d, input string req);
    bit k;
    b_start();
    send_byte(dev(pins, 0), k); chk(req, k, 1);
    send_byte(a[15:8], k);      chk(req, k, 1);
    send_byte(a[7:0], k);       chk(req, k, 1);
    send_byte(d, k);            chk(req, k, 1);
    b_stop();
    cyc(WT);
  endtask

  function automatic logic [7:0] pg_exp(input int i);
    case (i)
      30: return 8'hD0;
      31: return 8'hD1;
      0:  return 8'hD2;
      1:  return 8'hD3;
      default: return 8'(i * 7 + 3);
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit k;
    logic [7:0] b;
    cyc(5);
    chk("R1 reset sda released", dut_oe, 0);
    rst_n = 1'b1;
    cyc(5);
    chk("R1 idle after reset", dut_oe, 0);

    // R1: matching byte without a START
    m_scl = 1'b0; cyc(Q);
    send_byte(dev(pins, 0), k); chk("R1 no start no ack", k, 0);
    b_stop();

    // R2: sweep strap pins against device select bits
    for (int p = 0; p < 8; p++) begin
      pins = 3'(p);
      cyc(4);
      for (int a = 0; a < 8; a++) begin
        b_start();
        send_byte(dev(3'(a), 0), k);
        chk("R2 select sweep", k, (a == p) ? 1 : 0);
        b_stop();
      end
    end
    pins = 3'd5;
    cyc(4);
    b_start(); send_byte({4'b1011, pins, 1'b0}, k); chk("R2 wrong code", k, 0); b_stop();

    // R3/R4: single write with junk in the upper address bits, R8 busy window
    b_start();
    send_byte(dev(pins, 0), k); chk("R3 dev ack", k, 1);
    send_byte(8'hF9, k);        chk("R3 addr hi ack", k, 1);
    send_byte(8'h23, k);        chk("R3 addr lo ack", k, 1);
    send_byte(8'h5A, k);        chk("R3 data ack", k, 1);
    b_stop();
    b_start(); send_byte(dev(pins, 0), k); chk("R8 busy no ack", k, 0); b_stop();
    cyc(WT);
    rd_point(16'h0123, "R8 ack after window");
    recv_byte(b, 0); chk("R4 low bits addr", b, 8'h5A);
    b_stop();

    // R7: repeated START discards buffered data
    b_start();
    send_byte(dev(pins, 0), k); chk("R7 ack", k, 1);
    send_byte(8'h01, k); send_byte(8'h23, k);
    send_byte(8'hEE, k);        chk("R7 data ack", k, 1);
    rd_point(16'h0123, "R7 restart");
    recv_byte(b, 0); chk("R7 discarded", b, 8'h5A);
    b_stop();
    cyc(WT);

    // R9: full page, then a write that wraps inside the page
    b_start();
    send_byte(dev(pins, 0), k); send_byte(8'h00, k); send_byte(8'h40, k);
    for (int i = 0; i < 32; i++) begin
      send_byte(8'(i * 7 + 3), k); chk("R3 page data ack", k, 1);
    end
    b_stop(); cyc(WT);
    b_start();
    send_byte(dev(pins, 0), k); send_byte(8'h00, k); send_byte(8'h5E, k);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'hD0 + 8'(i), k); chk("R9 wrap ack", k, 1);
    end
    b_stop(); cyc(WT);

    // R5/R11: short sequential read, then current-address read
    rd_point(16'h0040, "R5 point");
    for (int i = 0; i < 4; i++) begin
      recv_byte(b, i < 3); chk("R5 sequential", b, pg_exp(i));
    end
    b_stop();
    b_start(); send_byte(dev(pins, 1), k); chk("R11 dev ack", k, 1);
    recv_byte(b, 0); chk("R11 current addr", b, pg_exp(4));
    b_stop();

    rd_point(16'h0040, "R9 point");
    for (int i = 0; i < 32; i++) begin
      recv_byte(b, i < 31); chk("R9 page content", b, pg_exp(i));
    end
    b_stop();

    // R10: read wraps from top address to zero
    wr_byte(16'h07FF, 8'h77, "R10 write top");
    wr_byte(16'h0000, 8'h11, "R10 write zero");
    rd_point(16'h07FF, "R10 point");
    recv_byte(b, 1); chk("R10 top", b, 8'h77);
    recv_byte(b, 0); chk("R10 wrapped", b, 8'h11);
    b_stop();

    // R12: write protect on the upper quarter
    wr_byte(16'h0600, 8'h33, "R12 open write");
    wp = 1'b1;
    wr_byte(16'h0600, 8'hCC, "R12 locked write");
    wr_byte(16'h05FF, 8'h44, "R12 below zone");
    rd_point(16'h05FF, "R12 point");
    recv_byte(b, 1); chk("R12 below zone written", b, 8'h44);
    recv_byte(b, 0); chk("R12 locked unchanged", b, 8'h33);
    b_stop();
    wp = 1'b0;
    wr_byte(16'h0600, 8'hCC, "R12 unlocked write");
    rd_point(16'h0600, "R12 point2");
    recv_byte(b, 0); chk("R12 unlocked written", b, 8'hCC);
    b_stop();

    // R6: after master no-ack the line stays released
    rd_point(16'h0123, "R6 point");
    recv_byte(b, 0); chk("R6 byte", b, 8'h5A);
    recv_byte(b, 0); chk("R6 released after nack", b, 8'hFF);
    b_stop();
    chk("R1 released after stop", dut_oe, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule